// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block generates the active-low reset that holds a microcontroller in reset. Two conditions can cause a reset. The first is a digitized supply-good flag: when that flag drops, reset asserts, and it stays asserted until the flag has stayed high for a fixed hold interval. The second is a watchdog, which the host restarts by pulling its chip-select line from high to low. That same line also selects the serial bus. If the host never produces that falling edge within the programmed period, the block emits a reset pulse of fixed length and then starts counting again.

All timing is measured in ticks of a millisecond timebase input, and every interval is a tick-count parameter. A 2-bit code selects the watchdog period. A new code becomes active only when a command-complete strobe arrives or at power-up reset, so the period cannot change in the middle of a transaction. While the supply hold interval runs, a comms-inhibit output tells the serial interface to abort and refuse traffic.

Top module: `supply_wdog_supervisor`

## Requirements
- R1: During and right after the synchronous reset `rst_n`, `reset_n_out` is 0 and `comms_block` is 1.
- R2: A clock edge that samples `supply_ok` low drives `reset_n_out` to 0 and `comms_block` to 1 after that edge.
- R3: `reset_n_out` is released only after PURST_TICKS ticks have been counted with `supply_ok` high throughout. A low sample of `supply_ok` restarts the count from zero.
- R4: `comms_block` is 1 exactly while the supply hold interval is not complete, and `reset_n_out` is never 1 while `comms_block` is 1.
- R5: Only a synchronized high-to-low transition of `cs_wdi` restarts the watchdog. A rising edge, or the line held at either level, does not restart it.
- R6: With the active code 2'b00, 2'b01 or 2'b10, the watchdog count runs WD_LONG_TICKS, WD_MID_TICKS or WD_SHORT_TICKS ticks respectively. If no restart occurs in that window, `reset_n_out` goes to 0 on the last tick.
- R7: Active code 2'b11 disables the watchdog, so no watchdog reset occurs whatever `cs_wdi` does. 2'b11 is the default expected at power-up.
- R8: A watchdog reset lasts RST_PULSE_TICKS ticks. After it ends, the watchdog count starts again from zero.
- R9: A change on `wd_code` becomes active only on a cycle with `cmd_done` high, or during `rst_n`.
- R10: A restart that lands after the (period-1)th tick, but before the expiring tick, prevents the reset and begins a full new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| tick_ms | input | 1 | One-cycle timebase tick (nominally 1 ms) |
| supply_ok | input | 1 | Synchronous supply-good flag from the comparator |
| cs_wdi | input | 1 | Shared chip-select and watchdog restart line |
| wd_code | input | 2 | Requested watchdog period code |
| cmd_done | input | 1 | One-cycle strobe marking a completed read or write command |
| reset_n_out | output | 1 | Active-low reset to the host |
| comms_block | output | 1 | High while serial traffic must be aborted |

## Verification
The hardest case to reach from the ports is a restart that arrives within the last tick of a period. Because of the synchronizer, the restart edge reaches the counter three clocks late. The stimulus therefore aligns each restart to a known tick phase: it drives `cs_wdi` low just after an observed tick, so that the counter clears before the next one. It then repeats this after exactly period-1 ticks. Randomized restarts, supply dips and code changes run against a cycle-level reference model to cover the remaining phase alignments.

// File: rtl/sup_pkg.sv
// Package: shared types and helpers for the supply/watchdog supervisor.
// Assumes: nothing beyond IEEE 1800-2017 elaboration-time functions.
package sup_pkg;

    // Watchdog period selection; encoding is visible at the wd_code port.
    typedef enum logic [1:0] {
        WD_LONG  = 2'b00,
        WD_MID   = 2'b01,
        WD_SHORT = 2'b10,
        WD_OFF   = 2'b11
    } wd_sel_e;

    // Largest of three tick counts, used to size the watchdog counter.
    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sup_wdi_sync.sv
// Module: sup_wdi_sync
// Brings the asynchronous chip-select/watchdog line into the clock domain
// through SYNC_STAGES flops, then flags one cycle per high-to-low transition.
// Assumes: the line idles high, so the chain resets to ones and no false
// restart appears when reset is released.
module sup_wdi_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_wdi,
    output logic kick
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the raw line through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[CHAIN_W-2:0], cs_wdi};
        end
    end

    // A falling edge: the older sample was high, the newer one is low.
    assign kick = chain[CHAIN_W-1] & ~chain[CHAIN_W-2];

endmodule

// File: rtl/sup_power_hold.sv
// Module: sup_power_hold
// Tracks the supply-good flag and declares the supply settled only after
// PURST_TICKS timebase ticks with the flag continuously high.
// Assumes: supply_ok is already synchronous to clk.
module sup_power_hold #(
    parameter int PURST_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ms,
    input  logic supply_ok,
    output logic pu_done
);

    localparam int PW = (PURST_TICKS > 1) ? $clog2(PURST_TICKS + 1) : 1;
    localparam logic [PW-1:0] LAST = PW'(PURST_TICKS - 1);

    logic [PW-1:0] hold_cnt;

    // Count ticks while the supply is good; any low sample starts over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_cnt <= '0;
            pu_done  <= 1'b0;
        end else if (!supply_ok) begin
            hold_cnt <= '0;
            pu_done  <= 1'b0;
        end else if (!pu_done && tick_ms) begin
            if (hold_cnt == LAST) begin
                pu_done <= 1'b1;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sup_code_latch.sv
// Module: sup_code_latch
// Holds the watchdog period code that is actually in force. A requested
// code is adopted only at reset or on a command-complete strobe.
// Assumes: cmd_done is a single-cycle pulse from the serial front end.
module sup_code_latch (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           wd_code,
    input  logic                 cmd_done,
    output sup_pkg::wd_sel_e     act_code
);

    // Load the requested code at power-up or when a command completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_code <= sup_pkg::wd_sel_e'(wd_code);
        end else if (cmd_done) begin
            act_code <= sup_pkg::wd_sel_e'(wd_code);
        end
    end

endmodule

// File: rtl/sup_wdog_timer.sv
// Module: sup_wdog_timer
// Counts timebase ticks between restarts. When the count reaches the
// period chosen by the active code, the module raises a reset pulse for
// RST_PULSE_TICKS ticks and then counts from zero again.
// Assumes: the timer only runs once the supply hold interval is complete.
// Restarts seen during a pulse are ignored. If a restart and a tick land
// in the same cycle, the restart wins.
module sup_wdog_timer #(
    parameter int WD_LONG_TICKS   = 1400,
    parameter int WD_MID_TICKS    = 600,
    parameter int WD_SHORT_TICKS  = 200,
    parameter int RST_PULSE_TICKS = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             pu_done,
    input  logic             kick,
    input  sup_pkg::wd_sel_e act_code,
    output logic             wd_pulse
);
    import sup_pkg::*;

    localparam int MAXP = max_of3(WD_LONG_TICKS, WD_MID_TICKS, WD_SHORT_TICKS);
    localparam int CW   = $clog2(MAXP + 1);
    localparam int RW   = (RST_PULSE_TICKS > 1) ? $clog2(RST_PULSE_TICKS + 1) : 1;
    localparam logic [RW-1:0] PULSE_LAST = RW'(RST_PULSE_TICKS - 1);

    logic [CW-1:0] wd_cnt;
    logic [CW-1:0] wd_last;
    logic [RW-1:0] pulse_cnt;
    logic          wd_enabled;

    // Select the final count value for the active period code.
    always_comb begin
        wd_enabled = 1'b1;
        unique case (act_code)
            WD_LONG:  wd_last = CW'(WD_LONG_TICKS - 1);
            WD_MID:   wd_last = CW'(WD_MID_TICKS - 1);
            WD_SHORT: wd_last = CW'(WD_SHORT_TICKS - 1);
            default: begin
                wd_last    = '0;
                wd_enabled = 1'b0;
            end
        endcase
    end

    // Period counter and reset-pulse timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_cnt    <= '0;
            pulse_cnt <= '0;
            wd_pulse  <= 1'b0;
        end else if (!pu_done) begin
            wd_cnt    <= '0;
            pulse_cnt <= '0;
            wd_pulse  <= 1'b0;
        end else if (wd_pulse) begin
            if (tick_ms) begin
                if (pulse_cnt == PULSE_LAST) begin
                    wd_pulse  <= 1'b0;
                    pulse_cnt <= '0;
                    wd_cnt    <= '0;
                end else begin
                    pulse_cnt <= pulse_cnt + 1'b1;
                end
            end
        end else if (!wd_enabled || kick) begin
            wd_cnt <= '0;
        end else if (tick_ms) begin
            if (wd_cnt == wd_last) begin
                wd_pulse <= 1'b1;
                wd_cnt   <= '0;
            end else begin
                wd_cnt <= wd_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/supply_wdog_supervisor.sv
// Module: supply_wdog_supervisor (top)
// Combines the supply hold timer and the watchdog into one active-low reset
// output. It also raises comms_block while the supply is not settled.
// Assumes: tick_ms is a one-cycle strobe synchronous to clk; cs_wdi may be
// asynchronous; rst_n is the synchronous power-up reset.
module supply_wdog_supervisor #(
    parameter int PURST_TICKS     = 200,
    parameter int WD_LONG_TICKS   = 1400,
    parameter int WD_MID_TICKS    = 600,
    parameter int WD_SHORT_TICKS  = 200,
    parameter int RST_PULSE_TICKS = 200,
    parameter int SYNC_STAGES     = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       supply_ok,
    input  logic       cs_wdi,
    input  logic [1:0] wd_code,
    input  logic       cmd_done,
    output logic       reset_n_out,
    output logic       comms_block
);

    logic             kick;
    logic             pu_done;
    logic             wd_pulse;
    sup_pkg::wd_sel_e act_code;

    sup_wdi_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_wdi (cs_wdi),
        .kick   (kick)
    );

    sup_power_hold #(.PURST_TICKS(PURST_TICKS)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_ms   (tick_ms),
        .supply_ok (supply_ok),
        .pu_done   (pu_done)
    );

    sup_code_latch u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .wd_code  (wd_code),
        .cmd_done (cmd_done),
        .act_code (act_code)
    );

    sup_wdog_timer #(
        .WD_LONG_TICKS   (WD_LONG_TICKS),
        .WD_MID_TICKS    (WD_MID_TICKS),
        .WD_SHORT_TICKS  (WD_SHORT_TICKS),
        .RST_PULSE_TICKS (RST_PULSE_TICKS)
    ) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_ms  (tick_ms),
        .pu_done  (pu_done),
        .kick     (kick),
        .act_code (act_code),
        .wd_pulse (wd_pulse)
    );

    // Either cause holds the host in reset; traffic waits on the supply only.
    assign reset_n_out = pu_done & ~wd_pulse;
    assign comms_block = ~pu_done;

endmodule

// File: rtl/supply_wdog_supervisor_chk.sv
// Module: supply_wdog_supervisor_chk
// Temporal checks on the supervisor, attached to the top module by bind.
// Assumes: it is bound to supply_wdog_supervisor and sees its internal
// pu_done, act_code and wd_pulse nets.
module supply_wdog_supervisor_chk (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_ms,
    input logic             supply_ok,
    input logic             cmd_done,
    input logic             pu_done,
    input sup_pkg::wd_sel_e act_code,
    input logic             wd_pulse,
    input logic             reset_n_out,
    input logic             comms_block
);

    // R2
    supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !reset_n_out);

    // R4
    comms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        comms_block |-> !reset_n_out);

    // R3
    release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reset_n_out) |-> ($past(tick_ms) && $past(supply_ok)));

    // R7
    off_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_pulse) |-> ($past(act_code) != sup_pkg::WD_OFF));

    // R9
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |=> $stable(act_code));

    // R8
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_pulse) |-> ($past(tick_ms) || !$past(pu_done)));

endmodule

bind supply_wdog_supervisor supply_wdog_supervisor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_ms     (tick_ms),
    .supply_ok   (supply_ok),
    .cmd_done    (cmd_done),
    .pu_done     (pu_done),
    .act_code    (act_code),
    .wd_pulse    (wd_pulse),
    .reset_n_out (reset_n_out),
    .comms_block (comms_block)
);

// File: tb/sim_supply_wdog_supervisor.sv
// Bench for supply_wdog_supervisor: directed timing checks plus seeded
// random stimulus compared against a cycle-level reference model.
module sim_supply_wdog_supervisor;

    localparam int PU    = 8;
    localparam int LONGP = 40;
    localparam int MIDP  = 24;
    localparam int SHRT  = 12;
    localparam int PULSE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b0;
    logic       supply_ok = 1'b1;
    logic       cs_wdi = 1'b1;
    logic [1:0] wd_code = 2'b11;
    logic       cmd_done = 1'b0;
    logic       reset_n_out;
    logic       comms_block;

    int checks = 0;
    int errors = 0;
    int tphase = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    supply_wdog_supervisor #(
        .PURST_TICKS(PU), .WD_LONG_TICKS(LONGP), .WD_MID_TICKS(MIDP),
        .WD_SHORT_TICKS(SHRT), .RST_PULSE_TICKS(PULSE), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .supply_ok(supply_ok),
        .cs_wdi(cs_wdi), .wd_code(wd_code), .cmd_done(cmd_done),
        .reset_n_out(reset_n_out), .comms_block(comms_block)
    );

    // Timebase: one tick every 4 clocks, driven away from the active edge.
    always @(negedge clk) begin
        tphase  <= (tphase + 1) % 4;
        tick_ms <= (tphase == 3);
    end

    // Reference model built from the requirements.
    logic h1 = 1, h2 = 1, h3 = 1;
    int   m_pu = 0, m_wc = 0, m_pc = 0;
    bit   m_ok = 0, m_pl = 0;
    logic [1:0] m_code = 2'b11;

    function automatic int period_of(input logic [1:0] c);
        case (c)
            2'b00:   return LONGP;
            2'b01:   return MIDP;
            2'b10:   return SHRT;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            h1 <= 1; h2 <= 1; h3 <= 1;
            m_pu <= 0; m_ok <= 0; m_code <= wd_code;
            m_wc <= 0; m_pc <= 0; m_pl <= 0;
        end else begin
            h1 <= cs_wdi; h2 <= h1; h3 <= h2;
            if (cmd_done) m_code <= wd_code;
            if (!supply_ok) begin
                m_pu <= 0; m_ok <= 0;
            end else if (!m_ok && tick_ms) begin
                if (m_pu == PU - 1) m_ok <= 1; else m_pu <= m_pu + 1;
            end
            if (!m_ok) begin
                m_wc <= 0; m_pc <= 0; m_pl <= 0;
            end else if (m_pl) begin
                if (tick_ms) begin
                    if (m_pc == PULSE - 1) begin m_pl <= 0; m_pc <= 0; m_wc <= 0; end
                    else m_pc <= m_pc + 1;
                end
            end else if (m_code == 2'b11 || (h3 && !h2)) begin
                m_wc <= 0;
            end else if (tick_ms) begin
                if (m_wc == period_of(m_code) - 1) begin m_pl <= 1; m_wc <= 0; end
                else m_wc <= m_wc + 1;
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Compare both outputs against the model on every falling edge.
    bit cmp_en = 0;
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(m_ok ? "R6 model reset_n_out" : "R3 model reset_n_out",
                reset_n_out, m_ok && !m_pl);
            chk("R4 model comms_block", comms_block, !m_ok);
        end
    end

    // Return just after the posedge of the nth tick from now.
    task automatic tick_wait(input int n);
        repeat (n) begin
            @(posedge clk);
            while (!tick_ms) @(posedge clk);
        end
    endtask

    // Falling edge on cs_wdi, cleared in the counter before the next tick
    // when called right after a tick edge.
    task automatic kick_now(input bit hold_low);
        @(negedge clk) cs_wdi = 1'b0;
        repeat (3) @(negedge clk);
        if (!hold_low) cs_wdi = 1'b1;
    endtask

    task automatic kick_aligned(input bit hold_low);
        tick_wait(1);
        kick_now(hold_low);
    endtask

    task automatic load_code(input logic [1:0] c);
        @(negedge clk) begin wd_code = c; cmd_done = 1'b1; end
        @(negedge clk) cmd_done = 1'b0;
    endtask

    task automatic expect_timeout(input string req, input int per);
        tick_wait(per - 1);
        @(negedge clk) chk(req, reset_n_out, 1'b1);
        tick_wait(1);
        @(negedge clk) chk(req, reset_n_out, 1'b0);
        tick_wait(PULSE);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd4711);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset_n_out", reset_n_out, 1'b0);
        chk("R1 comms_block", comms_block, 1'b1);
        cmp_en = 1;

        // R3: release after exactly PU ticks
        tick_wait(PU - 1);
        @(negedge clk) chk("R3 before hold end", reset_n_out, 1'b0);
        tick_wait(1);
        @(negedge clk) begin
            chk("R3 released", reset_n_out, 1'b1);
            chk("R4 comms free", comms_block, 1'b0);
        end

        // R2: brownout, then a dip restarts the hold count
        @(negedge clk) supply_ok = 1'b0;
        @(negedge clk) begin
            chk("R2 reset on drop", reset_n_out, 1'b0);
            chk("R2 comms on drop", comms_block, 1'b1);
        end
        repeat (5) @(negedge clk);
        supply_ok = 1'b1;
        tick_wait(3);
        @(negedge clk) supply_ok = 1'b0;
        @(negedge clk) supply_ok = 1'b1;
        tick_wait(PU - 1);
        @(negedge clk) chk("R3 dip restarted count", reset_n_out, 1'b0);
        tick_wait(1);
        @(negedge clk) chk("R3 release after dip", reset_n_out, 1'b1);

        // R7: disabled code, no restarts for a long time
        tick_wait(3 * LONGP);
        @(negedge clk) chk("R7 disabled no reset", reset_n_out, 1'b1);

        // R9: requested code not adopted without cmd_done
        @(negedge clk) wd_code = 2'b10;
        tick_wait(SHRT + 3);
        @(negedge clk) chk("R9 code held back", reset_n_out, 1'b1);
        load_code(2'b10);

        // R6 short period, R8 pulse length and restart
        kick_aligned(0);
        tick_wait(SHRT - 1);
        @(negedge clk) chk("R6 short before expiry", reset_n_out, 1'b1);
        tick_wait(1);
        @(negedge clk) chk("R6 short expiry", reset_n_out, 1'b0);
        tick_wait(PULSE - 1);
        @(negedge clk) chk("R8 pulse still low", reset_n_out, 1'b0);
        tick_wait(1);
        @(negedge clk) chk("R8 pulse ended", reset_n_out, 1'b1);
        tick_wait(SHRT - 1);
        @(negedge clk) chk("R8 recount before expiry", reset_n_out, 1'b1);
        tick_wait(1);
        @(negedge clk) chk("R8 recount expiry", reset_n_out, 1'b0);
        tick_wait(PULSE);

        // R10: restart just before expiry
        kick_aligned(0);
        tick_wait(SHRT - 1);
        kick_now(0);
        expect_timeout("R10 late restart", SHRT);

        // R5: held low after one fall; a rising edge does not restart
        kick_aligned(1);
        tick_wait(SHRT - 2);
        @(negedge clk) cs_wdi = 1'b1;
        tick_wait(1);
        @(negedge clk) chk("R5 rise ignored", reset_n_out, 1'b1);
        tick_wait(1);
        @(negedge clk) chk("R5 timeout despite rise", reset_n_out, 1'b0);
        tick_wait(PULSE);

        // R6: mid and long periods
        load_code(2'b01);
        kick_aligned(0);
        expect_timeout("R6 mid period", MIDP);
        load_code(2'b00);
        kick_aligned(0);
        expect_timeout("R6 long period", LONGP);

        // Random mix checked against the model
        for (int i = 0; i < 500; i++) begin
            int unsigned act;
            act = $urandom_range(0, 9);
            if (act < 5) begin
                @(negedge clk) cs_wdi = 1'b0;
                repeat ($urandom_range(1, 6)) @(negedge clk);
                cs_wdi = 1'b1;
                repeat ($urandom_range(1, 30)) @(negedge clk);
            end else if (act < 7) begin
                repeat ($urandom_range(1, 60)) @(negedge clk);
            end else if (act == 7) begin
                @(negedge clk) supply_ok = 1'b0;
                repeat ($urandom_range(1, 12)) @(negedge clk);
                supply_ok = 1'b1;
            end else begin
                @(negedge clk) begin
                    wd_code  = 2'($urandom_range(0, 3));
                    cmd_done = ($urandom_range(0, 1) == 1);
                end
                @(negedge clk) cmd_done = 1'b0;
            end
        end

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule